// File: doc/BRIEF.md
# Redundant Thread Store Comparator

This block checks two copies of one program that run side by side as a leading thread and a trailing thread. Each thread hands over its committed stores, an address and a data word, as it retires them. The block keeps a separate in-order queue per thread and compares the two oldest entries whenever both queues hold something. A matching pair leaves both queues together. A differing pair raises a sticky fault and freezes both queues until the fault is cleared.

Each thread gets a stall output that goes high while its queue is full. The thread's commit stage uses it to hold back any store at the head of its retire window. Two saturating counters report the current slack: how many cycles the oldest store of one thread has waited while the partner queue stayed empty. This shows how far the trailing thread lags, or how far it runs ahead.

Top module: `store_pair_checker`

## Requirements
- R1: Each thread's stores leave its queue in the order they were pushed. Comparison is always between the oldest entry of each queue, so the n-th store of one thread is paired with the n-th store of the other.
- R2: `pair_match` is high in a cycle when both queues are non-empty, their oldest entries are equal in both address and data, and no fault is held. On the following clock edge both oldest entries are removed.
- R3: A thread's stall output is high exactly when its queue holds DEPTH entries (default 16). A push to a full queue is ignored and leaves the queue contents unchanged.
- R4: When both queues are non-empty, their oldest entries differ and no fault is held, `fault` goes high at the next clock edge. At that edge the fault outputs capture both oldest entries: the leading thread's address and data, and the trailing thread's address and data.
- R5: While `fault` is high and `fault_clr` is low, `fault` stays high, the captured values stay unchanged and nothing leaves either queue. A clock edge with `fault` high and `fault_clr` high clears `fault` and discards the oldest entry of each queue. `fault_clr` has no effect while `fault` is low.
- R6: `lead_slack` adds one at each clock edge where the leading queue is non-empty and the trailing queue is empty. It returns to zero at the edge where a pair leaves the queues, and otherwise holds.
- R7: `trail_slack` adds one at each clock edge where the trailing queue is non-empty and the leading queue is empty. It returns to zero at the edge where a pair leaves the queues, and otherwise holds.
- R8: Both slack counters saturate at 2^SLACK_W-1 and do not wrap. The default width of 20 bits covers about a million cycles.
- R9: After a synchronous active-low reset, both queues are empty, both stall outputs are low, `pair_match` and `fault` are low, and both slack counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lead_push | input | 1 | Leading thread commits a store this cycle |
| lead_addr | input | ADDR_W | Address of the leading thread's store |
| lead_data | input | DATA_W | Data of the leading thread's store |
| lead_stall | output | 1 | Leading queue is full; hold store commits |
| trail_push | input | 1 | Trailing thread commits a store this cycle |
| trail_addr | input | ADDR_W | Address of the trailing thread's store |
| trail_data | input | DATA_W | Data of the trailing thread's store |
| trail_stall | output | 1 | Trailing queue is full; hold store commits |
| fault_clr | input | 1 | Clears a held fault and discards the offending pair |
| pair_match | output | 1 | Oldest entries agree; they are removed at the next edge |
| fault | output | 1 | Sticky mismatch flag |
| fault_lead_addr | output | ADDR_W | Captured leading address of the mismatch |
| fault_lead_data | output | DATA_W | Captured leading data of the mismatch |
| fault_trail_addr | output | ADDR_W | Captured trailing address of the mismatch |
| fault_trail_data | output | DATA_W | Captured trailing data of the mismatch |
| lead_slack | output | SLACK_W | Cycles the leading oldest store has waited for its partner |
| trail_slack | output | SLACK_W | Cycles the trailing oldest store has waited for its partner |

## Verification
The bench fills the leading queue past its depth while the trailing side stays idle. A design that accepted the extra push would overwrite the oldest store, and the later drain would then report a false fault. Both waiting directions are held long enough to saturate a narrowed slack counter; a wrapping counter would fall back to small values. A mismatch is followed by matching stores and a delayed clear, which exposes a design that keeps popping during a fault, lets the captured pair drift, or clears without discarding the bad pair. Long random runs with a biased push rate per thread mix full queues, simultaneous arrival and a rare corrupted store.

// File: rtl/store_cmp_pkg.sv
// Shared definitions for the redundant thread store comparator.
// Assumes nothing beyond plain synthesizable types.
package store_cmp_pkg;
    localparam int unsigned DEF_ADDR_W  = 32;
    localparam int unsigned DEF_DATA_W  = 32;
    localparam int unsigned DEF_DEPTH   = 16;
    localparam int unsigned DEF_SLACK_W = 20;

    // Which thread's oldest store is currently waiting alone.
    typedef enum logic [1:0] {
        WAIT_NONE  = 2'd0,
        WAIT_LEAD  = 2'd1,
        WAIT_TRAIL = 2'd2
    } wait_side_e;
endpackage

// File: rtl/store_fifo.sv
// In-order queue of committed stores for one thread.
// Push is dropped when full, even if a pop happens in the same cycle.
// Assumes pop is only requested while the queue is not empty.
module store_fifo #(
    parameter int unsigned WIDTH = 64,
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    // R3
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R3
    push_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop |=> full && $stable(rd_ptr) && $stable(wr_ptr));
endmodule

// File: rtl/slack_ctr.sv
// Saturating cycle counter for the waiting time of one thread's oldest store.
// Clear has priority over increment.
module slack_ctr #(
    parameter int unsigned WIDTH = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] value
);
    localparam logic [WIDTH-1:0] MAXV = '1;

    // Count waiting cycles, stop at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                     value <= '0;
        else if (clr)                   value <= '0;
        else if (inc && value != MAXV)  value <= value + 1'b1;
    end

    // R8
    slack_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        value == MAXV && !clr |=> value == MAXV);
endmodule

// File: rtl/store_pair_checker.sv
// Compares the committed stores of a leading and a trailing redundant thread.
// One queue per thread; oldest entries are compared when both exist.
// A match removes both; a mismatch latches a sticky fault that freezes the
// queues until fault_clr discards the offending pair.
// Assumes threads honour their stall outputs; pushes while full are dropped.
module store_pair_checker
    import store_cmp_pkg::*;
#(
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    parameter int unsigned DATA_W  = DEF_DATA_W,
    parameter int unsigned DEPTH   = DEF_DEPTH,
    parameter int unsigned SLACK_W = DEF_SLACK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lead_push,
    input  logic [ADDR_W-1:0]  lead_addr,
    input  logic [DATA_W-1:0]  lead_data,
    output logic               lead_stall,
    input  logic               trail_push,
    input  logic [ADDR_W-1:0]  trail_addr,
    input  logic [DATA_W-1:0]  trail_data,
    output logic               trail_stall,
    input  logic               fault_clr,
    output logic               pair_match,
    output logic               fault,
    output logic [ADDR_W-1:0]  fault_lead_addr,
    output logic [DATA_W-1:0]  fault_lead_data,
    output logic [ADDR_W-1:0]  fault_trail_addr,
    output logic [DATA_W-1:0]  fault_trail_data,
    output logic [SLACK_W-1:0] lead_slack,
    output logic [SLACK_W-1:0] trail_slack
);
    localparam int unsigned WORD_W  = ADDR_W + DATA_W;
    localparam int unsigned THREADS = 2;

    logic [THREADS-1:0] push_v, empty_v, full_v;
    logic [WORD_W-1:0]  word_in [THREADS];
    logic [WORD_W-1:0]  head    [THREADS];
    logic [SLACK_W-1:0] slack_v [THREADS];

    logic              both_valid, same, hit, miss, drop, pop_both;
    logic              fault_q;
    logic [WORD_W-1:0] cap_lead, cap_trail;
    wait_side_e        side;

    assign push_v     = {trail_push, lead_push};
    assign word_in[0] = {lead_addr, lead_data};
    assign word_in[1] = {trail_addr, trail_data};

    assign both_valid = !empty_v[0] && !empty_v[1];
    assign same       = (head[0] == head[1]);
    assign hit        = both_valid && same && !fault_q;
    assign miss       = both_valid && !same && !fault_q;
    assign drop       = fault_q && fault_clr;
    assign pop_both   = hit || drop;

    // Decide which thread's oldest store is waiting without a partner.
    always_comb begin
        side = WAIT_NONE;
        if (!empty_v[0] && empty_v[1])      side = WAIT_LEAD;
        else if (empty_v[0] && !empty_v[1]) side = WAIT_TRAIL;
    end

    // One queue and one slack counter per thread.
    for (genvar t = 0; t < THREADS; t++) begin : g_thread
        localparam wait_side_e MY_SIDE = (t == 0) ? WAIT_LEAD : WAIT_TRAIL;

        store_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_v[t]),
            .din   (word_in[t]),
            .pop   (pop_both),
            .head  (head[t]),
            .empty (empty_v[t]),
            .full  (full_v[t])
        );

        slack_ctr #(.WIDTH(SLACK_W)) u_slack (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (pop_both),
            .inc   (side == MY_SIDE),
            .value (slack_v[t])
        );
    end

    // Sticky fault flag with capture of the mismatching pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q   <= 1'b0;
            cap_lead  <= '0;
            cap_trail <= '0;
        end else if (drop) begin
            fault_q <= 1'b0;
        end else if (miss) begin
            fault_q   <= 1'b1;
            cap_lead  <= head[0];
            cap_trail <= head[1];
        end
    end

    assign lead_stall       = full_v[0];
    assign trail_stall      = full_v[1];
    assign pair_match       = hit;
    assign fault            = fault_q;
    assign fault_lead_addr  = cap_lead[WORD_W-1 -: ADDR_W];
    assign fault_lead_data  = cap_lead[DATA_W-1:0];
    assign fault_trail_addr = cap_trail[WORD_W-1 -: ADDR_W];
    assign fault_trail_data = cap_trail[DATA_W-1:0];
    assign lead_slack       = slack_v[0];
    assign trail_slack      = slack_v[1];

    // R5
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q && !fault_clr |=> fault_q);

    // R5
    capture_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q && !fault_clr |=> $stable(cap_lead) && $stable(cap_trail));

    // R6
    slack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_match |=> lead_slack == '0 && trail_slack == '0);

    // R4
    fault_pair_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> cap_lead != cap_trail);
endmodule

// File: tb/store_pair_checker_tb_top.sv
// Bench: directed corners plus seeded random traffic, checked every cycle
// against a queue-based reference model built from the requirements.
module store_pair_checker_tb_top;
    localparam int unsigned AW = 32;
    localparam int unsigned DW = 32;
    localparam int unsigned D  = 16;
    localparam int unsigned SW = 6;
    localparam logic [SW-1:0] SMAX = '1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          lead_push, trail_push, fault_clr;
    logic [AW-1:0] lead_addr, trail_addr;
    logic [DW-1:0] lead_data, trail_data;
    logic          lead_stall, trail_stall, pair_match, fault;
    logic [AW-1:0] fault_lead_addr, fault_trail_addr;
    logic [DW-1:0] fault_lead_data, fault_trail_data;
    logic [SW-1:0] lead_slack, trail_slack;

    always #2.5 clk = ~clk;

    store_pair_checker #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(D), .SLACK_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lead_push(lead_push), .lead_addr(lead_addr), .lead_data(lead_data),
        .lead_stall(lead_stall),
        .trail_push(trail_push), .trail_addr(trail_addr), .trail_data(trail_data),
        .trail_stall(trail_stall),
        .fault_clr(fault_clr), .pair_match(pair_match), .fault(fault),
        .fault_lead_addr(fault_lead_addr), .fault_lead_data(fault_lead_data),
        .fault_trail_addr(fault_trail_addr), .fault_trail_data(fault_trail_data),
        .lead_slack(lead_slack), .trail_slack(trail_slack)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state.
    logic [63:0]   lq[$];
    logic [63:0]   tq[$];
    logic          m_flt;
    logic [63:0]   m_cl, m_ct;
    logic [SW-1:0] m_ls, m_ts;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] w(input int i);
        return {32'h1000_0000 + 32'(i * 4), ~32'(i)};
    endfunction

    function automatic logic exp_hit();
        return lq.size() > 0 && tq.size() > 0 && lq[0] == tq[0] && !m_flt;
    endfunction

    task automatic check_outputs();
        chk("R3 lead_stall",  64'(lead_stall),  64'(lq.size() == D));
        chk("R3 trail_stall", 64'(trail_stall), 64'(tq.size() == D));
        chk("R1 R2 pair_match", 64'(pair_match), 64'(exp_hit()));
        chk("R4 R5 fault", 64'(fault), 64'(m_flt));
        if (m_flt) begin
            chk("R4 captured lead",  {fault_lead_addr, fault_lead_data},   m_cl);
            chk("R4 captured trail", {fault_trail_addr, fault_trail_data}, m_ct);
        end
        chk("R6 R8 lead_slack",  64'(lead_slack),  64'(m_ls));
        chk("R7 R8 trail_slack", 64'(trail_slack), 64'(m_ts));
    endtask

    task automatic model_edge(input logic lp, input logic [63:0] lw,
                              input logic tp, input logic [63:0] tw, input logic clr);
        logic both, hit, miss, drop, pop, lfull, tfull;
        both  = lq.size() > 0 && tq.size() > 0;
        hit   = exp_hit();
        miss  = both && lq[0] != tq[0] && !m_flt;
        drop  = m_flt && clr;
        pop   = hit || drop;
        lfull = lq.size() == D;
        tfull = tq.size() == D;
        if (pop) begin
            m_ls = '0;
            m_ts = '0;
        end else begin
            if (lq.size() > 0 && tq.size() == 0 && m_ls != SMAX) m_ls = m_ls + 1'b1;
            if (tq.size() > 0 && lq.size() == 0 && m_ts != SMAX) m_ts = m_ts + 1'b1;
        end
        if (drop) m_flt = 1'b0;
        else if (miss) begin
            m_flt = 1'b1;
            m_cl  = lq[0];
            m_ct  = tq[0];
        end
        if (pop) begin
            void'(lq.pop_front());
            void'(tq.pop_front());
        end
        if (lp && !lfull) lq.push_back(lw);
        if (tp && !tfull) tq.push_back(tw);
    endtask

    // One cycle: check at negedge, drive, clock, advance model.
    task automatic step(input logic lp, input logic [63:0] lw,
                        input logic tp, input logic [63:0] tw, input logic clr);
        check_outputs();
        lead_push  = lp; {lead_addr, lead_data}   = lw;
        trail_push = tp; {trail_addr, trail_data} = tw;
        fault_clr  = clr;
        @(posedge clk);
        model_edge(lp, lw, tp, tw, clr);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, 1'b0);
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] seq[$];
        int li, ti, lp_pct, tp_pct;
        void'($urandom(32'd20240611));
        lead_push = 0; trail_push = 0; fault_clr = 0;
        lead_addr = '0; lead_data = '0; trail_addr = '0; trail_data = '0;
        m_flt = 0; m_cl = '0; m_ct = '0; m_ls = '0; m_ts = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk);

        // R9 reset state
        chk("R9 lead_stall", 64'(lead_stall), 64'd0);
        chk("R9 trail_stall", 64'(trail_stall), 64'd0);
        chk("R9 pair_match", 64'(pair_match), 64'd0);
        chk("R9 fault", 64'(fault), 64'd0);
        chk("R9 slack", {lead_slack, trail_slack}, 64'd0);

        // R3 fill the leading queue and push once more while full
        for (int i = 0; i <= D; i++) step(1'b1, w(i), 1'b0, '0, 1'b0);
        chk("R3 stall when full", 64'(lead_stall), 64'd1);
        step(1'b1, w(999), 1'b0, '0, 1'b0);
        // R8 saturate leading slack
        idle(70);
        chk("R8 lead_slack saturated", 64'(lead_slack), 64'(SMAX));
        // R1 drain in order: a dropped overwrite would show as a fault
        for (int i = 0; i < D; i++) step(1'b0, '0, 1'b1, w(i), 1'b0);
        idle(3);
        chk("R1 drained without fault", 64'(fault), 64'd0);
        chk("R3 stall released", 64'(lead_stall), 64'd0);

        // R7 R8 trailing thread runs ahead
        step(1'b0, '0, 1'b1, w(100), 1'b0);
        idle(70);
        chk("R7 trail_slack saturated", 64'(trail_slack), 64'(SMAX));
        step(1'b1, w(100), 1'b0, '0, 1'b0);
        chk("R2 late partner matches", 64'(pair_match), 64'd1);
        idle(1);
        chk("R7 trail_slack cleared", 64'(trail_slack), 64'd0);

        // R4 R5 mismatch, hold, clear
        step(1'b1, w(200), 1'b1, w(201), 1'b0);
        step(1'b1, w(202), 1'b1, w(202), 1'b0);
        chk("R4 fault raised", 64'(fault), 64'd1);
        idle(5);
        chk("R5 fault held", 64'(fault), 64'd1);
        chk("R5 no match during fault", 64'(pair_match), 64'd0);
        step(1'b0, '0, 1'b0, '0, 1'b1);
        chk("R5 fault cleared", 64'(fault), 64'd0);
        chk("R5 next pair compares", 64'(pair_match), 64'd1);
        idle(3);
        step(1'b0, '0, 1'b0, '0, 1'b1);
        chk("R5 clear without fault ignored", 64'(fault), 64'd0);

        // Random traffic with biased push rates and rare corruption
        li = 0; ti = 0;
        for (int seg = 0; seg < 12; seg++) begin
            lp_pct = (seg % 3 == 0) ? 90 : ((seg % 3 == 1) ? 15 : 50);
            tp_pct = (seg % 4 == 0) ? 10 : ((seg % 4 == 1) ? 85 : 50);
            for (int c = 0; c < 300; c++) begin
                logic lp, tp, clr;
                logic [63:0] lw, tw;
                lp = ($urandom % 100) < lp_pct;
                tp = ($urandom % 100) < tp_pct;
                while (seq.size() <= li || seq.size() <= ti)
                    seq.push_back({$urandom, $urandom});
                lw = seq[li];
                tw = seq[ti];
                if ($urandom % 150 == 0) tw[0] = ~tw[0];
                clr = m_flt && ($urandom % 8 == 0);
                if (lp && lq.size() < D) li++;
                if (tp && tq.size() < D) ti++;
                step(lp, lw, tp, tw, clr);
            end
        end
        idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule